// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block sits beside a processor's control-register file and decides, each cycle, whether a pending exception or a hardware interrupt is accepted. When one is accepted it performs every state change of entry at once: the saved copies of the status word, program counter and stack register are written, the status word is forced into privileged, blocked, alternate-bank state, the event code is recorded, and the program counter is loaded with the handler address.

An exception always wins over an interrupt. While the block bit of the status word is set, an exception is turned into a reset event (with one resumable code exempt), and interrupts are refused unless the core was halted when they arrived. Handler addresses come from three offsets off the vector base, or from a fixed reset address for reset-class codes. The saved PC is corrected for delay-slot faults and for the trap instruction.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When exc_valid_i and an acceptable interrupt arrive in the same cycle, the exception is taken: expevt_o gets the exception code and intevt_o keeps its value.
- R2: With SR bit 28 (block) set, an exception with any code other than 0x1E0 is recorded as 0x000 and handled as reset class; code 0x1E0 passes unchanged.
- R3: With SR bit 28 set, an interrupt is refused unless halt_irq_i is high; when taken that way, halt_clr_o pulses with taken_o.
- R4: An interrupt is taken only when irq_level_i is strictly greater than SR[7:4]; otherwise no output changes.
- R5: On entry ssr_o = sr_i, spc_o = pc_i, sgr_o = r15_i, and sr_o = sr_i with bits 28, 29 and 30 set.
- R6: With dslot_i high, spc_o = pc_i - 2 and dslot_clr_o pulses with taken_o.
- R7: Codes 0x000, 0x020 and 0x140 load pc_o = 0xA0000000, clear SR bit 15 and force SR[7:4] = 0xF.
- R8: Codes 0x040 and 0x060 load pc_o = vbr_i + 0x400; every other non-reset exception loads vbr_i + 0x100.
- R9: Code 0x160 saves spc_o = pc_i + 2 (added after any delay-slot correction).
- R10: An interrupt writes irq_code_i to intevt_o, loads pc_o = vbr_i + 0x600, and leaves expevt_o unchanged.
- R11: All outputs update on the rising edge after the inputs; taken_o is high for exactly that cycle; with nothing taken every register holds.
- R12: Reset gives sr_o = 0x700000F0 (bits 28, 30, 29 set and mask 0xF), pc_o = 0xA0000000, all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Exception pending |
| exc_code_i | input | 12 | Exception event code |
| irq_req_i | input | 1 | Interrupt pending |
| irq_level_i | input | 4 | Interrupt priority level |
| irq_code_i | input | 12 | Interrupt event code |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| vbr_i | input | 32 | Vector base |
| r15_i | input | 32 | Current stack register |
| dslot_i | input | 1 | Faulting instruction is in a delay slot |
| halt_irq_i | input | 1 | Interrupt arrived while halted |
| taken_o | output | 1 | Entry performed this cycle |
| halt_clr_o | output | 1 | Clear the halt flag |
| dslot_clr_o | output | 1 | Clear the delay-slot flags |
| pc_o | output | 32 | New program counter |
| sr_o | output | 32 | New status word |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack register |
| expevt_o | output | 12 | Exception event register |
| intevt_o | output | 12 | Interrupt event register |

## Verification
Every result is registered once, so each output is due on the first rising edge after the stimulus is applied. The bench drives inputs on a falling edge, checks at the following falling edge, then returns the inputs to idle, so the one-cycle strobes and the held registers are both sampled mid-cycle. Refusal cases are checked by showing taken_o low and pc_o unchanged in that same sample.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 12;
  localparam int LVL_W  = 4;

  localparam int SR_MD  = 30;
  localparam int SR_RB  = 29;
  localparam int SR_BL  = 28;
  localparam int SR_FD  = 15;
  localparam int SR_IM_LO = 4;

  localparam logic [CODE_W-1:0] C_RESET   = 12'h000;
  localparam logic [CODE_W-1:0] C_MANRST  = 12'h020;
  localparam logic [CODE_W-1:0] C_MULTI   = 12'h140;
  localparam logic [CODE_W-1:0] C_MISS_RD = 12'h040;
  localparam logic [CODE_W-1:0] C_MISS_WR = 12'h060;
  localparam logic [CODE_W-1:0] C_TRAP    = 12'h160;
  localparam logic [CODE_W-1:0] C_RESUME  = 12'h1E0;

  localparam logic [XLEN-1:0] RESET_PC  = 32'hA000_0000;
  localparam logic [XLEN-1:0] OFF_GEN   = 32'h0000_0100;
  localparam logic [XLEN-1:0] OFF_MISS  = 32'h0000_0400;
  localparam logic [XLEN-1:0] OFF_IRQ   = 32'h0000_0600;

  typedef enum logic [1:0] {ENT_NONE, ENT_EXC, ENT_IRQ} entry_e;
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
(
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic [LVL_W-1:0]  irq_level_i,
  input  logic              sr_bl_i,
  input  logic [LVL_W-1:0]  sr_imask_i,
  input  logic              halt_irq_i,
  output entry_e            kind_o,
  output logic [CODE_W-1:0] eff_code_o,
  output logic              halt_clr_o
);
  logic irq_ok;

  // blocked state refuses irqs unless woken from halt
  assign irq_ok = irq_req_i && (irq_level_i > sr_imask_i) && (!sr_bl_i || halt_irq_i);

  always_comb begin
    kind_o     = ENT_NONE;
    eff_code_o = exc_code_i;
    halt_clr_o = 1'b0;
    if (exc_valid_i) begin
      kind_o = ENT_EXC;
      if (sr_bl_i && exc_code_i != C_RESUME) eff_code_o = C_RESET;
    end else if (irq_ok) begin
      kind_o     = ENT_IRQ;
      halt_clr_o = halt_irq_i;
    end
  end
endmodule

// File: rtl/exc_vec.sv
module exc_vec
  import exc_pkg::*;
(
  input  entry_e            kind_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic              dslot_i,
  output logic [XLEN-1:0]   new_pc_o,
  output logic [XLEN-1:0]   new_sr_o,
  output logic [XLEN-1:0]   new_spc_o
);
  logic rst_class, miss_class, is_trap;
  logic [XLEN-1:0] spc_adj;

  assign rst_class  = (kind_i == ENT_EXC) &&
                      (code_i == C_RESET || code_i == C_MANRST || code_i == C_MULTI);
  assign miss_class = (code_i == C_MISS_RD || code_i == C_MISS_WR);
  assign is_trap    = (kind_i == ENT_EXC) && (code_i == C_TRAP);

  always_comb begin
    spc_adj = pc_i;
    if (dslot_i) spc_adj = spc_adj - 32'd2;
    if (is_trap) spc_adj = spc_adj + 32'd2;
    new_spc_o = spc_adj;

    new_sr_o = sr_i;
    new_sr_o[SR_BL] = 1'b1;
    new_sr_o[SR_MD] = 1'b1;
    new_sr_o[SR_RB] = 1'b1;
    if (rst_class) begin
      new_sr_o[SR_FD] = 1'b0;
      new_sr_o[SR_IM_LO +: LVL_W] = '1;
    end

    if (kind_i == ENT_IRQ)  new_pc_o = vbr_i + OFF_IRQ;
    else if (rst_class)     new_pc_o = RESET_PC;
    else if (miss_class)    new_pc_o = vbr_i + OFF_MISS;
    else                    new_pc_o = vbr_i + OFF_GEN;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic [LVL_W-1:0]  irq_level_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic              dslot_i,
  input  logic              halt_irq_i,
  output logic              taken_o,
  output logic              halt_clr_o,
  output logic              dslot_clr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o
);
  localparam logic [XLEN-1:0] SR_RST =
    (XLEN'(1) << SR_BL) | (XLEN'(1) << SR_MD) | (XLEN'(1) << SR_RB) |
    (XLEN'((1 << LVL_W) - 1) << SR_IM_LO);

  entry_e            kind;
  logic [CODE_W-1:0] eff_code;
  logic              hclr;
  logic [XLEN-1:0]   new_pc, new_sr, new_spc;

  exc_arb u_arb (
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .irq_req_i   (irq_req_i),
    .irq_level_i (irq_level_i),
    .sr_bl_i     (sr_i[SR_BL]),
    .sr_imask_i  (sr_i[SR_IM_LO +: LVL_W]),
    .halt_irq_i  (halt_irq_i),
    .kind_o      (kind),
    .eff_code_o  (eff_code),
    .halt_clr_o  (hclr)
  );

  exc_vec u_vec (
    .kind_i    (kind),
    .code_i    (eff_code),
    .pc_i      (pc_i),
    .vbr_i     (vbr_i),
    .sr_i      (sr_i),
    .dslot_i   (dslot_i),
    .new_pc_o  (new_pc),
    .new_sr_o  (new_sr),
    .new_spc_o (new_spc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o     <= 1'b0;
      halt_clr_o  <= 1'b0;
      dslot_clr_o <= 1'b0;
      pc_o        <= RESET_PC;
      sr_o        <= SR_RST;
      ssr_o       <= '0;
      spc_o       <= '0;
      sgr_o       <= '0;
      expevt_o    <= '0;
      intevt_o    <= '0;
    end else begin
      taken_o     <= (kind != ENT_NONE);
      halt_clr_o  <= hclr;
      dslot_clr_o <= (kind != ENT_NONE) && dslot_i;
      if (kind != ENT_NONE) begin
        pc_o  <= new_pc;
        sr_o  <= new_sr;
        ssr_o <= sr_i;
        spc_o <= new_spc;
        sgr_o <= r15_i;
        if (kind == ENT_EXC) expevt_o <= eff_code;
        else                 intevt_o <= irq_code_i;
      end
    end
  end

  AST_EXC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> (taken_o && $stable(intevt_o))); // R1

  AST_BL_TO_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && sr_i[SR_BL] && exc_code_i != C_RESUME) |=>
      (expevt_o == C_RESET && pc_o == RESET_PC)); // R2

  AST_BL_IRQ_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_valid_i && sr_i[SR_BL] && !halt_irq_i) |=> !taken_o); // R3

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_valid_i && irq_level_i <= sr_i[SR_IM_LO +: LVL_W]) |=> (!taken_o && $stable(pc_o))); // R4

  AST_ENTRY_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (sr_o[SR_BL] && sr_o[SR_MD] && sr_o[SR_RB])); // R5

  AST_IRQ_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_valid_i && irq_req_i && !sr_i[SR_BL] && irq_level_i > sr_i[SR_IM_LO +: LVL_W]) |=>
      (pc_o == $past(vbr_i) + OFF_IRQ && $stable(expevt_o))); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_valid_i && !irq_req_i) |=>
      (!taken_o && $stable(pc_o) && $stable(sr_o) && $stable(spc_o))); // R11
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        exc_v = 0, irq = 0, dslot = 0, halt = 0;
  logic [11:0] exc_code = 0, irq_code = 0;
  logic [3:0]  lvl = 0;
  logic [31:0] sr = 0, pc = 0, vbr = 0, r15 = 0;
  logic        taken, hclr, dclr;
  logic [31:0] pc_o, sr_o, ssr_o, spc_o, sgr_o;
  logic [11:0] expevt, intevt;
  int checks = 0, errors = 0;

  localparam logic [31:0] SR0 = 32'h0000_8030; // FD set, mask 3
  localparam logic [31:0] SRB = 32'h1000_8030; // plus block bit
  localparam logic [31:0] PC0 = 32'h0C00_1000;
  localparam logic [31:0] VB0 = 32'h8C00_0000;
  localparam logic [31:0] R0  = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  exc_entry_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(exc_v), .exc_code_i(exc_code),
    .irq_req_i(irq), .irq_level_i(lvl), .irq_code_i(irq_code), .sr_i(sr),
    .pc_i(pc), .vbr_i(vbr), .r15_i(r15), .dslot_i(dslot), .halt_irq_i(halt),
    .taken_o(taken), .halt_clr_o(hclr), .dslot_clr_o(dclr), .pc_o(pc_o),
    .sr_o(sr_o), .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o),
    .expevt_o(expevt), .intevt_o(intevt));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    exc_v = 0; irq = 0; dslot = 0; halt = 0; lvl = 0;
    sr = SR0; pc = PC0; vbr = VB0; r15 = R0;
  endtask

  // drive at negedge, result due at next posedge, sample at following negedge
  task automatic fire();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R12 sr", sr_o, 32'h7000_00F0);
    chk("R12 pc", pc_o, 32'hA000_0000);
    chk("R12 taken", {31'd0, taken}, 0);
    chk("R12 expevt", {20'd0, expevt}, 0);
  endtask

  task automatic t_general();
    exc_v = 1; exc_code = 12'h180;
    fire();
    chk("R11 taken", {31'd0, taken}, 1);
    chk("R8 pc general", pc_o, VB0 + 32'h100);
    chk("R5 ssr", ssr_o, SR0);
    chk("R5 spc", spc_o, PC0);
    chk("R5 sgr", sgr_o, R0);
    chk("R5 sr", sr_o, 32'h7000_8030);
    chk("R1 expevt", {20'd0, expevt}, 32'h180);
    chk("R6 no dslot clr", {31'd0, dclr}, 0);
    @(negedge clk);
    chk("R11 strobe one cycle", {31'd0, taken}, 0);
    chk("R11 hold pc", pc_o, VB0 + 32'h100);
  endtask

  task automatic t_tlb();
    exc_v = 1; exc_code = 12'h040;
    fire();
    chk("R8 miss read", pc_o, VB0 + 32'h400);
    exc_v = 1; exc_code = 12'h060;
    fire();
    chk("R8 miss write", pc_o, VB0 + 32'h400);
  endtask

  task automatic t_reset_class();
    exc_v = 1; exc_code = 12'h140;
    fire();
    chk("R7 pc", pc_o, 32'hA000_0000);
    chk("R7 sr", sr_o, 32'h7000_00F0);
    exc_v = 1; exc_code = 12'h020;
    fire();
    chk("R7 code 020", pc_o, 32'hA000_0000);
  endtask

  task automatic t_trap();
    exc_v = 1; exc_code = 12'h160;
    fire();
    chk("R9 spc", spc_o, PC0 + 2);
    chk("R9 pc", pc_o, VB0 + 32'h100);
    exc_v = 1; exc_code = 12'h160; dslot = 1;
    fire();
    chk("R9 trap in slot", spc_o, PC0);
  endtask

  task automatic t_dslot();
    exc_v = 1; exc_code = 12'h180; dslot = 1;
    fire();
    chk("R6 spc", spc_o, PC0 - 2);
    chk("R6 dslot clr", {31'd0, dclr}, 1);
  endtask

  task automatic t_irq();
    irq = 1; lvl = 5; irq_code = 12'h3C0;
    fire();
    chk("R10 taken", {31'd0, taken}, 1);
    chk("R10 intevt", {20'd0, intevt}, 32'h3C0);
    chk("R10 pc", pc_o, VB0 + 32'h600);
    chk("R10 expevt kept", {20'd0, expevt}, 32'h180);
    chk("R4 no halt clr", {31'd0, hclr}, 0);
  endtask

  task automatic t_prio();
    exc_v = 1; exc_code = 12'h0A0; irq = 1; lvl = 9; irq_code = 12'h320;
    fire();
    chk("R1 expevt", {20'd0, expevt}, 32'h0A0);
    chk("R1 intevt kept", {20'd0, intevt}, 32'h3C0);
    chk("R1 pc", pc_o, VB0 + 32'h100);
  endtask

  task automatic t_mask();
    logic [31:0] pc_before;
    pc_before = pc_o;
    irq = 1; lvl = 3; irq_code = 12'h200;
    fire();
    chk("R4 refused taken", {31'd0, taken}, 0);
    chk("R4 refused pc", pc_o, pc_before);
    chk("R4 refused intevt", {20'd0, intevt}, 32'h3C0);
    irq = 1; lvl = 4; irq_code = 12'h240;
    fire();
    chk("R4 level above mask", {20'd0, intevt}, 32'h240);
  endtask

  task automatic t_block();
    logic [31:0] pc_before;
    sr = SRB; exc_v = 1; exc_code = 12'h180;
    fire();
    chk("R2 expevt", {20'd0, expevt}, 0);
    chk("R2 pc", pc_o, 32'hA000_0000);
    chk("R2 sr", sr_o, 32'h7000_00F0);
    sr = SRB; exc_v = 1; exc_code = 12'h1E0;
    fire();
    chk("R2 resumable code", {20'd0, expevt}, 32'h1E0);
    chk("R2 resumable pc", pc_o, VB0 + 32'h100);
    pc_before = pc_o;
    sr = SRB; irq = 1; lvl = 12; irq_code = 12'h500;
    fire();
    chk("R3 refused", {31'd0, taken}, 0);
    chk("R3 refused pc", pc_o, pc_before);
    sr = SRB; irq = 1; lvl = 12; irq_code = 12'h500; halt = 1;
    fire();
    chk("R3 halt taken", {31'd0, taken}, 1);
    chk("R3 halt clr", {31'd0, hclr}, 1);
    chk("R3 intevt", {20'd0, intevt}, 32'h500);
  endtask

  task automatic t_idle();
    logic [31:0] p, s;
    p = pc_o; s = sr_o;
    @(negedge clk); @(negedge clk);
    chk("R11 idle taken", {31'd0, taken}, 0);
    chk("R11 idle pc", pc_o, p);
    chk("R11 idle sr", sr_o, s);
  endtask

  initial begin
    fork
      begin
        idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_general();
        t_tlb();
        t_reset_class();
        t_trap();
        t_dslot();
        exc_v = 1; exc_code = 12'h180;
        fire();
        t_irq();
        t_prio();
        t_mask();
        t_block();
        t_idle();
      end
      begin
        repeat (2000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule